// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a data cache placed between a processor's load/store port and a slower main memory that is addressed by 32-bit words. At its default size it stores 16 KB in two ways of 512 sets, with four-word (16-byte) lines. Every access looks up both ways of one set at the same time. A hit hands the word and the stored tag of the matching way straight back to the processor. A miss holds the processor in a stall while the whole line is brought in from memory.

Stores use write-through with write-allocate. A store that hits updates the cached word and also sends the word to memory. A store that misses first pulls the line into the cache and is then handled as a store hit. The way that a refill overwrites is picked per set: an empty way is used first, and once both ways hold lines, successive refills of that set take the two ways in turn.

The controller has three states. In `ST_LOOKUP` it serves hits. A miss moves it to `ST_REFILL`. A store hit moves it to `ST_WRITE`. `ST_REFILL` returns to `ST_LOOKUP` when the last word of the line is acknowledged, and `ST_WRITE` returns to `ST_LOOKUP` when the memory acknowledges the store. After a refill the lookup runs again, so an allocated store then takes the path `ST_LOOKUP` to `ST_WRITE`. While stalled, the processor keeps its request and address unchanged.

Top module: `assoc_dcache`

## Requirements
- R1: The byte address is split as follows. Bits [1:0] are ignored. The next log2(LINE_WORDS) bits select the word in the line. The next log2(SETS) bits select the set. All remaining upper bits form the tag. With the defaults this is word [3:2], set [12:4] and tag [31:13].
- R2: A load that hits raises `cpu_hit` and keeps `cpu_stall` low in the same cycle. In that cycle `cpu_rdata` carries the addressed word of the matching way, `cpu_tag_out` carries that way's tag, and no memory request is made.
- R3: A load that misses raises `cpu_stall` in its first cycle. The stall stays high until the line has been refilled. The lookup then repeats and completes as a hit that returns the memory word.
- R4: A refill makes one memory read per word of the line. The reads start at word 0 of the line and go up by one word address on each `mem_ack`.
- R5: After reset every line is invalid, so the first access to any address misses. With no request, `cpu_stall`, `cpu_hit` and `mem_req` are all low. A line becomes valid only when its last refill word is accepted.
- R6: On a miss the refill overwrites way 0 if it is empty, otherwise way 1 if it is empty. Once both ways are valid, the set's turn pointer chooses the way. The pointer starts at way 0 after reset and moves to the other way after each refill of that set. At most one way of a set ever matches a given tag.
- R7: A store that hits writes `cpu_wdata` into the cached word. It also issues one memory write of that word to the word address, and holds `cpu_stall` high until the memory write is acknowledged.
- R8: A store that misses first refills the line, then proceeds as in R7. Afterwards the cache and the memory both hold the new word, and the other words of the line come from memory.
- R9: Configured with 4 sets and one-word lines, the byte addresses 0x00, 0x20, 0x00, 0x1C, 0x00 give miss, miss, hit, miss, hit, which is a 40% hit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data from the matching way |
| cpu_tag_out | output | TAG_W | Tag stored in the matching way |
| cpu_hit | output | 1 | Lookup hit this cycle |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Memory completes the current word |

## Verification
Suppose a valid bit or a turn pointer holds the wrong value. The port then shows a hit or miss that differs from the policy in R6. This becomes visible at the next access to that set, in the first cycle of that access, and it also changes the stall length by a whole line refill. A wrong refill order, or a word stored at the wrong offset, only shows on a later load of that word as the wrong data. For that reason every word of a line is read back after its fill. A lost write-through shows up in the memory image as soon as the store completes.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_REFILL = 2'd1,
        ST_WRITE  = 2'd2
    } dc_state_e;

endpackage

// File: rtl/dcache_way.sv
module dcache_way #(
    parameter int TAG_W  = 19,
    parameter int SET_W  = 9,
    parameter int SETS   = 512,
    parameter int WORDS  = 2048,
    parameter int DATA_W = 32,
    localparam int FLAT_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  look_set,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [FLAT_W-1:0] look_flat,
    output logic              match,
    output logic              occupied,
    output logic [TAG_W-1:0]  tag_rd,
    output logic [DATA_W-1:0] data_rd,
    input  logic              inval,
    input  logic              seal,
    input  logic              word_we,
    input  logic [FLAT_W-1:0] word_flat,
    input  logic [DATA_W-1:0] word_data
);

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inval) begin
            valid_q[look_set] <= 1'b0;
        end else if (seal) begin
            valid_q[look_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (seal) begin
            tag_q[look_set] <= look_tag;
        end
        if (word_we) begin
            data_q[word_flat] <= word_data;
        end
    end

    always_comb begin
        occupied = valid_q[look_set];
        tag_rd   = tag_q[look_set];
        data_rd  = data_q[look_flat];
        match    = occupied && (tag_rd == look_tag);
    end

    // R5: a sealed line is valid in the next cycle
    p_seal_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seal |=> valid_q[$past(look_set)]);

    // R5: an evicted line stays invalid until its refill completes
    p_inval_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !valid_q[$past(look_set)]);

endmodule

// File: rtl/dcache_victim.sv
module dcache_victim #(
    parameter int SETS  = 512,
    parameter int SET_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set,
    input  logic             occ0,
    input  logic             occ1,
    input  logic             adv,
    input  logic             adv_way,
    output logic             pick
);

    logic [SETS-1:0] turn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turn_q <= '0;
        end else if (adv) begin
            turn_q[set] <= ~adv_way;
        end
    end

    always_comb begin
        if (!occ0) begin
            pick = 1'b0;
        end else if (!occ1) begin
            pick = 1'b1;
        end else begin
            pick = turn_q[set];
        end
    end

    // R6: after a refill the set's pointer names the other way
    p_turn_alternates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> turn_q[$past(set)] != $past(adv_way));

endmodule

// File: rtl/dcache_fsm.sv
module dcache_fsm
    import dcache_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter int LAST  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             hit_any,
    input  logic             mem_ack,
    output dc_state_e        state,
    output logic [CNT_W-1:0] cnt,
    output logic             stall,
    output logic             mem_req,
    output logic             mem_we,
    output logic             miss_start,
    output logic             fill_word,
    output logic             fill_last,
    output logic             store_done
);

    dc_state_e        state_q;
    dc_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (miss_start) begin
                cnt_q <= '0;
            end else if (fill_word) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        stall      = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        miss_start = 1'b0;
        fill_word  = 1'b0;
        fill_last  = 1'b0;
        store_done = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (req && !hit_any) begin
                    miss_start = 1'b1;
                    stall      = 1'b1;
                    state_d    = ST_REFILL;
                end else if (req && we) begin
                    stall   = 1'b1;
                    state_d = ST_WRITE;
                end
            end
            ST_REFILL: begin
                stall     = 1'b1;
                mem_req   = 1'b1;
                fill_word = mem_ack;
                fill_last = mem_ack && (cnt_q == CNT_W'(LAST));
                if (fill_last) begin
                    state_d = ST_LOOKUP;
                end
            end
            ST_WRITE: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                stall      = !mem_ack;
                store_done = mem_ack;
                if (mem_ack) begin
                    state_d = ST_LOOKUP;
                end
            end
            default: begin
                state_d = ST_LOOKUP;
            end
        endcase
    end

    assign state = state_q;
    assign cnt   = cnt_q;

    // R3: a miss starts a refill at word 0
    p_miss_enters_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_start |=> (state_q == ST_REFILL) && (cnt_q == '0));

    // R7: an acknowledged store releases the controller
    p_store_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |=> state_q == ST_LOOKUP);

endmodule

// File: rtl/assoc_dcache.sv
module assoc_dcache
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SETS       = 512,
    parameter int LINE_WORDS = 4,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int CNT_W   = (OFF_W > 0) ? OFF_W : 1,
    localparam int SET_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - 2 - OFF_W - SET_W,
    localparam int WADDR_W = ADDR_W - 2,
    localparam int WORDS   = SETS * LINE_WORDS,
    localparam int FLAT_W  = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic [TAG_W-1:0]   cpu_tag_out,
    output logic               cpu_hit,
    output logic               cpu_stall,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ack
);

    function automatic logic [FLAT_W-1:0] flat_of(input logic [SET_W-1:0] s,
                                                  input logic [CNT_W-1:0] o);
        int idx;
        idx = (int'(s) << OFF_W) + (int'(o) & (LINE_WORDS - 1));
        return FLAT_W'(idx);
    endfunction

    logic [WADDR_W-1:0] word_addr;
    logic               unused_byte_bits;
    logic [SET_W-1:0]   look_set;
    logic [TAG_W-1:0]   look_tag;
    logic [CNT_W-1:0]   look_off;

    assign word_addr        = cpu_addr[ADDR_W-1:2];
    assign unused_byte_bits = ^cpu_addr[1:0];
    assign look_set         = SET_W'(word_addr >> OFF_W);
    assign look_tag         = TAG_W'(word_addr >> (OFF_W + SET_W));
    assign look_off         = CNT_W'(word_addr & WADDR_W'(LINE_WORDS - 1));

    dc_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             miss_start;
    logic             fill_word;
    logic             fill_last;
    logic             store_done;
    logic [1:0]       match;
    logic [1:0]       occ;
    logic             hit_any;
    logic             hit_way;
    logic             pick;
    logic             victim_q;
    logic [TAG_W-1:0]  way_tag  [2];
    logic [DATA_W-1:0] way_data [2];
    logic [FLAT_W-1:0] look_flat;
    logic [FLAT_W-1:0] wr_flat;
    logic [DATA_W-1:0] wr_data;

    assign hit_any   = |match;
    assign hit_way   = match[1];
    assign look_flat = flat_of(look_set, look_off);
    assign wr_flat   = fill_word ? flat_of(look_set, cnt) : look_flat;
    assign wr_data   = fill_word ? mem_rdata : cpu_wdata;

    dcache_fsm #(
        .CNT_W (CNT_W),
        .LAST  (LINE_WORDS - 1)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cpu_req),
        .we         (cpu_we),
        .hit_any    (hit_any),
        .mem_ack    (mem_ack),
        .state      (state),
        .cnt        (cnt),
        .stall      (cpu_stall),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .miss_start (miss_start),
        .fill_word  (fill_word),
        .fill_last  (fill_last),
        .store_done (store_done)
    );

    for (genvar g = 0; g < 2; g++) begin : g_way
        dcache_way #(
            .TAG_W  (TAG_W),
            .SET_W  (SET_W),
            .SETS   (SETS),
            .WORDS  (WORDS),
            .DATA_W (DATA_W)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .look_set  (look_set),
            .look_tag  (look_tag),
            .look_flat (look_flat),
            .match     (match[g]),
            .occupied  (occ[g]),
            .tag_rd    (way_tag[g]),
            .data_rd   (way_data[g]),
            .inval     (miss_start && (pick == 1'(g))),
            .seal      (fill_last && (victim_q == 1'(g))),
            .word_we   ((fill_word && (victim_q == 1'(g))) ||
                        (store_done && (hit_way == 1'(g)))),
            .word_flat (wr_flat),
            .word_data (wr_data)
        );
    end

    dcache_victim #(
        .SETS  (SETS),
        .SET_W (SET_W)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (look_set),
        .occ0    (occ[0]),
        .occ1    (occ[1]),
        .adv     (fill_last),
        .adv_way (victim_q),
        .pick    (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_q <= 1'b0;
        end else if (miss_start) begin
            victim_q <= pick;
        end
    end

    always_comb begin
        cpu_hit     = (state == ST_LOOKUP) && cpu_req && hit_any;
        cpu_rdata   = hit_any ? way_data[hit_way] : '0;
        cpu_tag_out = hit_any ? way_tag[hit_way] : '0;
        mem_wdata   = cpu_wdata;
        if (state == ST_REFILL) begin
            mem_addr = (word_addr & ~WADDR_W'(LINE_WORDS - 1)) | WADDR_W'(cnt);
        end else begin
            mem_addr = word_addr;
        end
    end

    // R6: no two ways of a set hold the same tag
    p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R4: refill reads start at the line base
    p_refill_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_start |=> (mem_addr & WADDR_W'(LINE_WORDS - 1)) == '0);

    // R4: each acknowledged word advances the read address by one
    p_refill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL) && mem_ack && !fill_last
        |=> mem_addr == WADDR_W'($past(mem_addr) + 1'b1));

    // R3: the held request hits once its line is filled
    p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last && cpu_req |=> hit_any);

    // R2: a load hit neither stalls nor touches memory
    p_read_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit && !cpu_we |-> !cpu_stall && !mem_req);

endmodule

// File: tb/assoc_dcache_bench.sv
module dcache_mem_model #(
    parameter int WA    = 14,
    parameter int DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [WA-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          ack
);
    logic [31:0] store [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) store[i] = 32'h5A00_0000 + i * 32'h0001_0307;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= req && !ack;
    end

    always @(posedge clk) begin
        if (req && we && ack) store[addr[$clog2(DEPTH)-1:0]] <= wdata;
    end

    assign rdata = store[addr[$clog2(DEPTH)-1:0]];
endmodule

module assoc_dcache_bench;
    localparam int CLK_PERIOD = 10;

    logic clk, rst_n;
    int checks = 0;
    int errors = 0;

    // main instance: 4 sets, 4-word lines, 16-bit addresses, tag = addr[15:6]
    logic        cpu_req, cpu_we;
    logic [15:0] cpu_addr;
    logic [31:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
    logic [9:0]  cpu_tag_out;
    logic        cpu_hit, cpu_stall, mem_req, mem_we, mem_ack;
    logic [13:0] mem_addr;

    assoc_dcache #(.ADDR_W(16), .DATA_W(32), .SETS(4), .LINE_WORDS(4)) u_assoc_dcache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_tag_out(cpu_tag_out), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

    dcache_mem_model u_mem (.clk(clk), .rst_n(rst_n), .req(mem_req), .we(mem_we),
        .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata), .ack(mem_ack));

    // mini instance: 4 sets, one-word lines
    logic        m_req, m_we, m_hit, m_stall, m_mreq, m_mwe, m_ack;
    logic [15:0] m_addr;
    logic [31:0] m_wdata, m_rdata, m_mwdata, m_mrdata;
    logic [11:0] m_tag;
    logic [13:0] m_maddr;

    assoc_dcache #(.ADDR_W(16), .DATA_W(32), .SETS(4), .LINE_WORDS(1)) u_assoc_dcache_mini (
        .clk(clk), .rst_n(rst_n), .cpu_req(m_req), .cpu_we(m_we),
        .cpu_addr(m_addr), .cpu_wdata(m_wdata), .cpu_rdata(m_rdata),
        .cpu_tag_out(m_tag), .cpu_hit(m_hit), .cpu_stall(m_stall),
        .mem_req(m_mreq), .mem_we(m_mwe), .mem_addr(m_maddr),
        .mem_wdata(m_mwdata), .mem_rdata(m_mrdata), .mem_ack(m_ack));

    dcache_mem_model u_mem_mini (.clk(clk), .rst_n(rst_n), .req(m_mreq), .we(m_mwe),
        .addr(m_maddr), .wdata(m_mwdata), .rdata(m_mrdata), .ack(m_ack));

    // reference state
    logic [31:0] shadow [1024];
    logic [9:0]  rt [4][2];
    bit          rv [4][2];
    bit          rr [4];
    int          nacks;
    logic [13:0] ack_log [8];

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    always @(posedge clk) begin
        if (mem_req && !mem_we && mem_ack) begin
            if (nacks < 8) ack_log[nacks] = mem_addr;
            nacks++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic access(input bit we, input logic [15:0] addr, input logic [31:0] wd);
        logic [13:0] word;
        logic [1:0]  set;
        logic [9:0]  tag;
        bit          exp_hit, got_hit;
        int          stalls, exp_stalls;
        logic [31:0] rd;
        logic [9:0]  tg;
        bit          v;
        word = addr[15:2];
        set  = word[3:2];
        tag  = word[13:4];
        exp_hit = (rv[set][0] && rt[set][0] == tag) || (rv[set][1] && rt[set][1] == tag);
        @(negedge clk);
        nacks = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        #1;
        got_hit = cpu_hit;
        stalls = 0;
        while (cpu_stall && stalls < 100) begin
            @(negedge clk);
            stalls++;
        end
        rd = cpu_rdata;
        tg = cpu_tag_out;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        // R6: hit/miss follows empty-first then alternating replacement
        chk(got_hit == exp_hit, "R6 hit/miss", 32'(got_hit), 32'(exp_hit));
        if (!we) begin
            exp_stalls = exp_hit ? 0 : 9;
            chk(stalls == exp_stalls, exp_hit ? "R2 load hit stall" : "R3 load miss stall",
                32'(stalls), 32'(exp_stalls));
            chk(rd == shadow[word], "R3 load data", rd, shadow[word]);
            chk(tg == tag, "R1 tag out", 32'(tg), 32'(tag));
            if (!exp_hit) begin
                chk(nacks == 4, "R4 refill reads", 32'(nacks), 32'd4);
                for (int k = 0; k < 4; k++)
                    chk(ack_log[k] == {word[13:2], 2'(k)}, "R4 refill order",
                        32'(ack_log[k]), 32'({word[13:2], 2'(k)}));
            end
        end else begin
            exp_stalls = exp_hit ? 2 : 11;
            chk(stalls == exp_stalls, exp_hit ? "R7 store hit stall" : "R8 store miss stall",
                32'(stalls), 32'(exp_stalls));
            shadow[word] = wd;
            chk(u_mem.store[word] == wd, "R7 write-through", u_mem.store[word], wd);
        end
        if (!exp_hit) begin
            v = !rv[set][0] ? 1'b0 : (!rv[set][1] ? 1'b1 : rr[set]);
            rt[set][v] = tag;
            rv[set][v] = 1'b1;
            rr[set] = ~v;
        end
    endtask

    task automatic mini_read(input logic [15:0] addr, input bit exp_hit, inout int hits);
        bit got;
        int stalls;
        @(negedge clk);
        m_req = 1'b1; m_addr = addr;
        #1;
        got = m_hit;
        stalls = 0;
        while (m_stall && stalls < 100) begin
            @(negedge clk);
            stalls++;
        end
        chk(got == exp_hit, "R9 example hit/miss", 32'(got), 32'(exp_hit));
        chk(m_rdata == 32'h5A00_0000 + 32'(addr[15:2]) * 32'h0001_0307, "R9 example data",
            m_rdata, 32'h5A00_0000 + 32'(addr[15:2]) * 32'h0001_0307);
        if (got) hits++;
        @(posedge clk);
        #1;
        m_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        int hits;
        for (int i = 0; i < 1024; i++) shadow[i] = 32'h5A00_0000 + i * 32'h0001_0307;
        for (int s = 0; s < 4; s++) begin
            rr[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin rv[s][w] = 1'b0; rt[s][w] = '0; end
        end
        cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        m_req = 0; m_we = 0; m_addr = 0; m_wdata = 0;
        nacks = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: idle outputs after reset
        chk(!cpu_stall, "R5 reset stall", 32'(cpu_stall), 0);
        chk(!cpu_hit, "R5 reset hit", 32'(cpu_hit), 0);
        chk(!mem_req, "R5 reset mem_req", 32'(mem_req), 0);

        // fill both ways of every set, each word, varying the ignored byte bits (R1, R5)
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++)
                    access(1'b0, {8'h00, 2'(t), 2'(s), 2'(w), 2'(w)}, 32'h0);

        // mixed loads and stores over four tags per set: evictions, write hits and misses
        seed = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            logic [31:0] d;
            bit          st;
            seed = seed * 32'd1664525 + 32'd1013904223;
            a  = {8'h00, seed[17:16], seed[9:8], seed[5:4], seed[1:0]};
            st = (seed[25:24] == 2'b00);
            seed = seed * 32'd1664525 + 32'd1013904223;
            d = seed;
            access(st, a, d);
        end

        // scaled example on one-word lines (R9)
        hits = 0;
        mini_read(16'h0000, 1'b0, hits);
        mini_read(16'h0020, 1'b0, hits);
        mini_read(16'h0000, 1'b1, hits);
        mini_read(16'h001C, 1'b0, hits);
        mini_read(16'h0000, 1'b1, hits);
        chk(hits * 100 / 5 == 40, "R9 hit rate", 32'(hits * 100 / 5), 32'd40);

        finish_run();
    end
endmodule